// File: doc/BRIEF.md
# USB Endpoint Packet Buffer Controller

This block stands between a USB serial engine and a shared local packet memory. The memory is 16 bits wide. When the engine starts a transaction, it names an endpoint and a direction. The controller looks up that endpoint's descriptor and picks one of the endpoint's two buffer slots. It then walks the buffer one byte at a time. On receive it packs incoming bytes into 16-bit words. On transmit it unpacks stored words into a byte stream. It keeps a running byte count as it goes.

Each endpoint has two slots. Each slot holds a word base address, a byte capacity and a byte count. For a single-buffered endpoint, slot 0 serves the device-to-host (transmit) direction and slot 1 serves the host-to-device (receive) direction. For a double-buffered endpoint, both directions use the slot chosen by a per-endpoint toggle bit. That toggle moves to the other slot only after a successful transaction, which leaves the other slot free for software. When a packet ends, the controller raises a one-cycle done pulse with the final count. On receive it also writes that count back into the slot's count field.

Top module: `usb_pktbuf_ctrl`

## Requirements
- R1: The slot used is chosen as follows. A single-buffered endpoint uses slot 0 when `sie_dir`=1 (transmit) and slot 1 when `sie_dir`=0 (receive). A double-buffered endpoint uses the slot equal to its toggle bit. Memory accesses start at the chosen slot's base word address.
- R2: On receive, byte number 2k of the packet lands in bits 7:0 and byte 2k+1 in bits 15:8 of word base+k. Each such word is written with a single `mem_we` cycle, in the cycle the odd byte arrives.
- R3: Received bytes beyond the slot capacity (in bytes) cause no memory write. `done_ovr` is 1 with the done pulse of such a packet and 0 otherwise.
- R4: If a received packet ends after an odd number of accepted bytes, the last word is written in the `sie_end` cycle with bits 15:8 set to 8'h00.
- R5: `done` is high for exactly one cycle, the cycle after `sie_end`. With it, `done_cnt` gives the bytes accepted (receive) or sent (transmit). After a receive, the slot's count field as read on `rd_cnt` equals that value.
- R6: On transmit, the number of bytes to send is the slot's count field. Each `tx_req` produces `tx_valid` in the next cycle. The bytes come out low byte before high byte, word by word from the base address.
- R7: During a transmit, `tx_eod` is 1 exactly when no bytes remain. A `tx_req` with no bytes remaining yields no `tx_valid`.
- R8: A double-buffered endpoint's toggle (`rd_tog`) flips at the end of a transaction only when `sie_ok`=1. A configuration write to the endpoint clears it to 0.
- R9: After reset, `done`, `tx_valid` and `mem_we` are 0 and every toggle reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one descriptor slot |
| cfg_ep | input | 3 | Endpoint for the configuration write |
| cfg_slot | input | 1 | Slot for the configuration write |
| cfg_base | input | 9 | Slot base word address |
| cfg_cap | input | 10 | Slot capacity in bytes |
| cfg_cnt | input | 10 | Slot byte count (transmit length) |
| cfg_dbl | input | 1 | Endpoint is double-buffered |
| rd_ep | input | 3 | Endpoint for readback |
| rd_slot | input | 1 | Slot for count readback |
| rd_cnt | output | 10 | Count field of the selected slot |
| rd_tog | output | 1 | Toggle bit of the selected endpoint |
| sie_start | input | 1 | Start of a transaction |
| sie_ep | input | 3 | Endpoint of the transaction |
| sie_dir | input | 1 | 1 = transmit to host, 0 = receive from host |
| sie_end | input | 1 | End of the transaction |
| sie_ok | input | 1 | Transaction completed successfully (with `sie_end`) |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next transmit byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_byte | output | 8 | Transmit byte |
| tx_eod | output | 1 | No transmit bytes remain |
| done | output | 1 | One-cycle end-of-packet pulse |
| done_cnt | output | 10 | Final byte count |
| done_ovr | output | 1 | Capacity overrun occurred |
| mem_we | output | 1 | Packet memory write strobe |
| mem_re | output | 1 | Packet memory read strobe |
| mem_addr | output | 9 | Packet memory word address |
| mem_wdata | output | 16 | Packet memory write data |
| mem_rdata | input | 16 | Packet memory read data, one cycle after `mem_re` |

## Verification
The bench sends a packet longer than its capacity. A design that skipped the guard would write words past the buffer and report a count above the capacity. Odd-length packets are sent to check the padded final word: a design that forgot to flush it would leave the last byte unwritten, and one that padded it wrongly would corrupt the upper half. On the double-buffered endpoint, a failed transaction sits between two successful ones. A toggle that flipped on every end would then send the third packet to the wrong base address. The transmit run reads a full odd-length buffer and then issues one extra request, to catch an off-by-one in the remaining count or a byte swap inside the word.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    parameter int PB_EPS = 8;                // endpoints
    parameter int PB_AW  = 9;                // word address bits
    parameter int PB_CW  = 10;               // byte count bits
    localparam int PB_EPW = $clog2(PB_EPS);

    typedef struct packed {
        logic [PB_AW-1:0] base;
        logic [PB_CW-1:0] cap;
        logic [PB_CW-1:0] cnt;
    } slot_desc_t;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_RX   = 2'd1,
        XS_TX   = 2'd2
    } xfer_state_e;

    // dir_in: 1 = transmit to host, 0 = receive from host
    function automatic logic pick_slot(input logic dbl, input logic tog, input logic dir_in);
        return dbl ? tog : ~dir_in;
    endfunction

endpackage

// File: rtl/pktbuf_desc.sv
module pktbuf_desc
    import pktbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PB_EPW-1:0] cfg_ep,
    input  logic              cfg_slot,
    input  slot_desc_t        cfg_word,
    input  logic              cfg_dbl,
    input  logic [PB_EPW-1:0] lk_ep,
    input  logic              lk_dir,
    output logic              lk_slot,
    output logic              lk_dbl,
    output slot_desc_t        lk_desc,
    input  logic              wb_we,
    input  logic [PB_EPW-1:0] wb_ep,
    input  logic              wb_slot,
    input  logic [PB_CW-1:0]  wb_cnt,
    input  logic              flip,
    input  logic [PB_EPW-1:0] flip_ep,
    input  logic [PB_EPW-1:0] rd_ep,
    input  logic              rd_slot,
    output logic [PB_CW-1:0]  rd_cnt,
    output logic              rd_tog
);

    slot_desc_t [PB_EPS-1:0] s0_v;
    slot_desc_t [PB_EPS-1:0] s1_v;
    logic       [PB_EPS-1:0] dbl_v;
    logic       [PB_EPS-1:0] tog_v;

    for (genvar e = 0; e < PB_EPS; e++) begin : g_ep
        slot_desc_t s0_q, s1_q;
        logic       dbl_q, tog_q;
        logic       cfg_hit, wb_hit, flip_hit;

        assign cfg_hit  = cfg_we && (cfg_ep == PB_EPW'(e));
        assign wb_hit   = wb_we && (wb_ep == PB_EPW'(e));
        assign flip_hit = flip && (flip_ep == PB_EPW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                s0_q  <= '0;
                s1_q  <= '0;
                dbl_q <= 1'b0;
                tog_q <= 1'b0;
            end else if (cfg_hit) begin
                if (cfg_slot) s1_q <= cfg_word;
                else          s0_q <= cfg_word;
                dbl_q <= cfg_dbl;
                tog_q <= 1'b0;
            end else begin
                if (wb_hit) begin
                    if (wb_slot) s1_q.cnt <= wb_cnt;
                    else         s0_q.cnt <= wb_cnt;
                end
                if (flip_hit) tog_q <= ~tog_q;
            end
        end

        assign s0_v[e]  = s0_q;
        assign s1_v[e]  = s1_q;
        assign dbl_v[e] = dbl_q;
        assign tog_v[e] = tog_q;
    end

    always_comb begin
        lk_dbl  = dbl_v[lk_ep];
        lk_slot = pick_slot(lk_dbl, tog_v[lk_ep], lk_dir);
        lk_desc = lk_slot ? s1_v[lk_ep] : s0_v[lk_ep];
        rd_cnt  = rd_slot ? s1_v[rd_ep].cnt : s0_v[rd_ep].cnt;
        rd_tog  = tog_v[rd_ep];
    end

    // R8: a toggle moves only after a flip request or a configuration write
    a_r8_toggle_source: assert property (@(posedge clk) disable iff (rst)
        (tog_v != $past(tog_v)) |-> $past(flip || cfg_we));

endmodule

// File: rtl/pktbuf_pack.sv
module pktbuf_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  rx_byte,
    input  logic        rx_lo,
    input  logic        rx_hi,
    input  logic        flush,
    input  logic        tx_fetch,
    input  logic        tx_take,
    input  logic        tx_req,
    input  logic [15:0] mem_rdata,
    output logic        mem_we,
    output logic [15:0] mem_wdata,
    output logic        mem_re,
    output logic        tx_valid,
    output logic [7:0]  tx_byte
);

    logic [15:0] hold_q;
    logic        pend_q;
    logic        pend_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            pend_q    <= 1'b0;
            pend_hi_q <= 1'b0;
        end else begin
            pend_q    <= tx_fetch || tx_take;
            pend_hi_q <= tx_take;
            if (rx_lo)
                hold_q[7:0] <= rx_byte;
            else if (pend_q && !pend_hi_q)
                hold_q <= mem_rdata;
        end
    end

    always_comb begin
        mem_we    = rx_hi || flush;
        mem_wdata = flush ? {8'h00, hold_q[7:0]} : {rx_byte, hold_q[7:0]};
        mem_re    = tx_fetch;
        tx_valid  = pend_q;
        tx_byte   = pend_hi_q ? hold_q[15:8] : mem_rdata[7:0];
    end

    // R6: a transmit byte only ever answers a request from the previous cycle
    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(tx_req));

    // R4: the padded flush never coincides with a regular pair write
    a_r4_flush_alone: assert property (@(posedge clk) disable iff (rst)
        flush |-> !rx_hi);

endmodule

// File: rtl/pktbuf_xfer.sv
module pktbuf_xfer
    import pktbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sie_start,
    input  logic [PB_EPW-1:0] sie_ep,
    input  logic              sie_dir,
    input  logic              sie_end,
    input  logic              sie_ok,
    input  logic              rx_valid,
    input  logic              tx_req,
    input  logic              lk_slot,
    input  logic              lk_dbl,
    input  slot_desc_t        lk_desc,
    output logic [PB_AW-1:0]  mem_addr,
    output logic              rx_lo,
    output logic              rx_hi,
    output logic              flush,
    output logic              tx_fetch,
    output logic              tx_take,
    output logic              tx_eod,
    output logic              wb_we,
    output logic [PB_EPW-1:0] wb_ep,
    output logic              wb_slot,
    output logic [PB_CW-1:0]  wb_cnt,
    output logic              flip,
    output logic [PB_EPW-1:0] flip_ep,
    output logic              done,
    output logic [PB_CW-1:0]  done_cnt,
    output logic              done_ovr
);

    xfer_state_e       st_q;
    logic [PB_EPW-1:0] ep_q;
    logic              slot_q;
    logic              dbl_q;
    logic [PB_AW-1:0]  base_q;
    logic [PB_AW-1:0]  waddr_q;
    logic [PB_CW-1:0]  nb_q;
    logic [PB_CW-1:0]  lim_q;
    logic [PB_CW-1:0]  rem_q;
    logic              ovr_q;
    logic              done_q;
    logic [PB_CW-1:0]  done_cnt_q;
    logic              done_ovr_q;

    logic rx_go, tx_go, room, end_go;

    always_comb begin
        rx_go    = (st_q == XS_RX) && rx_valid;
        tx_go    = (st_q == XS_TX) && tx_req && (rem_q != '0);
        room     = nb_q < lim_q;
        end_go   = (st_q != XS_IDLE) && sie_end;
        rx_lo    = rx_go && room && !nb_q[0];
        rx_hi    = rx_go && room && nb_q[0];
        tx_fetch = tx_go && !nb_q[0];
        tx_take  = tx_go && nb_q[0];
        flush    = end_go && (st_q == XS_RX) && nb_q[0];
        tx_eod   = (st_q == XS_TX) && (rem_q == '0);
        mem_addr = waddr_q;
        wb_we    = end_go && (st_q == XS_RX);
        wb_ep    = ep_q;
        wb_slot  = slot_q;
        wb_cnt   = nb_q;
        flip     = end_go && sie_ok && dbl_q;
        flip_ep  = ep_q;
        done     = done_q;
        done_cnt = done_cnt_q;
        done_ovr = done_ovr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= XS_IDLE;
            ep_q       <= '0;
            slot_q     <= 1'b0;
            dbl_q      <= 1'b0;
            base_q     <= '0;
            waddr_q    <= '0;
            nb_q       <= '0;
            lim_q      <= '0;
            rem_q      <= '0;
            ovr_q      <= 1'b0;
            done_q     <= 1'b0;
            done_cnt_q <= '0;
            done_ovr_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (st_q == XS_IDLE) begin
                if (sie_start) begin
                    st_q    <= sie_dir ? XS_TX : XS_RX;
                    ep_q    <= sie_ep;
                    slot_q  <= lk_slot;
                    dbl_q   <= lk_dbl;
                    base_q  <= lk_desc.base;
                    waddr_q <= lk_desc.base;
                    lim_q   <= lk_desc.cap;
                    rem_q   <= lk_desc.cnt;
                    nb_q    <= '0;
                    ovr_q   <= 1'b0;
                end
            end else if (end_go) begin
                st_q       <= XS_IDLE;
                done_q     <= 1'b1;
                done_cnt_q <= nb_q;
                done_ovr_q <= ovr_q;
            end else if (rx_go) begin
                if (room) begin
                    nb_q <= nb_q + PB_CW'(1);
                    if (nb_q[0]) waddr_q <= waddr_q + PB_AW'(1);
                end else begin
                    ovr_q <= 1'b1;
                end
            end else if (tx_go) begin
                nb_q  <= nb_q + PB_CW'(1);
                rem_q <= rem_q - PB_CW'(1);
                if (nb_q[0]) waddr_q <= waddr_q + PB_AW'(1);
            end
        end
    end

    // Assertions guarding the capacity and address logic
    logic [PB_AW-1:0] woff;
    assign woff = waddr_q - base_q;

    // R3: the accepted count never exceeds the slot capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_RX) |-> (nb_q <= lim_q));

    // R3: every memory write stays inside the buffer
    a_r3_write_in_bounds: assert property (@(posedge clk) disable iff (rst)
        (rx_hi || flush) |-> (int'(woff) < (int'(lim_q) + 1) / 2));

    // R2: completing a byte pair advances the word address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        rx_hi |=> (waddr_q == $past(waddr_q) + PB_AW'(1)));

    // R5: the done pulse lasts one cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R7: no byte is fetched once the remaining count is zero
    a_r7_no_fetch_at_eod: assert property (@(posedge clk) disable iff (rst)
        (tx_eod && tx_req) |=> !(st_q == XS_TX && $changed(nb_q)));

endmodule

// File: rtl/usb_pktbuf_ctrl.sv
module usb_pktbuf_ctrl
    import pktbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PB_EPW-1:0] cfg_ep,
    input  logic              cfg_slot,
    input  logic [PB_AW-1:0]  cfg_base,
    input  logic [PB_CW-1:0]  cfg_cap,
    input  logic [PB_CW-1:0]  cfg_cnt,
    input  logic              cfg_dbl,
    input  logic [PB_EPW-1:0] rd_ep,
    input  logic              rd_slot,
    output logic [PB_CW-1:0]  rd_cnt,
    output logic              rd_tog,
    input  logic              sie_start,
    input  logic [PB_EPW-1:0] sie_ep,
    input  logic              sie_dir,
    input  logic              sie_end,
    input  logic              sie_ok,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_eod,
    output logic              done,
    output logic [PB_CW-1:0]  done_cnt,
    output logic              done_ovr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [PB_AW-1:0]  mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata
);

    slot_desc_t        cfg_word, lk_desc;
    logic              lk_slot, lk_dbl;
    logic              rx_lo, rx_hi, flush, tx_fetch, tx_take;
    logic              wb_we, wb_slot, flip;
    logic [PB_EPW-1:0] wb_ep, flip_ep;
    logic [PB_CW-1:0]  wb_cnt;

    assign cfg_word = '{base: cfg_base, cap: cfg_cap, cnt: cfg_cnt};

    pktbuf_desc u_desc (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_ep   (cfg_ep),
        .cfg_slot (cfg_slot),
        .cfg_word (cfg_word),
        .cfg_dbl  (cfg_dbl),
        .lk_ep    (sie_ep),
        .lk_dir   (sie_dir),
        .lk_slot  (lk_slot),
        .lk_dbl   (lk_dbl),
        .lk_desc  (lk_desc),
        .wb_we    (wb_we),
        .wb_ep    (wb_ep),
        .wb_slot  (wb_slot),
        .wb_cnt   (wb_cnt),
        .flip     (flip),
        .flip_ep  (flip_ep),
        .rd_ep    (rd_ep),
        .rd_slot  (rd_slot),
        .rd_cnt   (rd_cnt),
        .rd_tog   (rd_tog)
    );

    pktbuf_xfer u_xfer (
        .clk       (clk),
        .rst       (rst),
        .sie_start (sie_start),
        .sie_ep    (sie_ep),
        .sie_dir   (sie_dir),
        .sie_end   (sie_end),
        .sie_ok    (sie_ok),
        .rx_valid  (rx_valid),
        .tx_req    (tx_req),
        .lk_slot   (lk_slot),
        .lk_dbl    (lk_dbl),
        .lk_desc   (lk_desc),
        .mem_addr  (mem_addr),
        .rx_lo     (rx_lo),
        .rx_hi     (rx_hi),
        .flush     (flush),
        .tx_fetch  (tx_fetch),
        .tx_take   (tx_take),
        .tx_eod    (tx_eod),
        .wb_we     (wb_we),
        .wb_ep     (wb_ep),
        .wb_slot   (wb_slot),
        .wb_cnt    (wb_cnt),
        .flip      (flip),
        .flip_ep   (flip_ep),
        .done      (done),
        .done_cnt  (done_cnt),
        .done_ovr  (done_ovr)
    );

    pktbuf_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .rx_byte   (rx_byte),
        .rx_lo     (rx_lo),
        .rx_hi     (rx_hi),
        .flush     (flush),
        .tx_fetch  (tx_fetch),
        .tx_take   (tx_take),
        .tx_req    (tx_req),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte)
    );

endmodule

// File: tb/sim_usb_pktbuf_ctrl.sv
`timescale 1ns/1ps
module sim_usb_pktbuf_ctrl;
    import pktbuf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0, cfg_slot = 1'b0, cfg_dbl = 1'b0;
    logic [PB_EPW-1:0] cfg_ep = '0, rd_ep = '0, sie_ep = '0;
    logic [PB_AW-1:0]  cfg_base = '0;
    logic [PB_CW-1:0]  cfg_cap = '0, cfg_cnt = '0;
    logic              rd_slot = 1'b0;
    logic [PB_CW-1:0]  rd_cnt;
    logic              rd_tog;
    logic              sie_start = 1'b0, sie_dir = 1'b0, sie_end = 1'b0, sie_ok = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_byte = '0;
    logic              tx_req = 1'b0;
    logic              tx_valid, tx_eod, done, done_ovr, mem_we, mem_re;
    logic [7:0]        tx_byte;
    logic [PB_CW-1:0]  done_cnt;
    logic [PB_AW-1:0]  mem_addr;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata = '0;

    logic [15:0] mem [2**PB_AW];

    logic [PB_AW+15:0] exp_wr[$];
    logic [7:0]        exp_tx[$];
    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    usb_pktbuf_ctrl u0 (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_slot(cfg_slot), .cfg_base(cfg_base),
        .cfg_cap(cfg_cap), .cfg_cnt(cfg_cnt), .cfg_dbl(cfg_dbl),
        .rd_ep(rd_ep), .rd_slot(rd_slot), .rd_cnt(rd_cnt), .rd_tog(rd_tog),
        .sie_start(sie_start), .sie_ep(sie_ep), .sie_dir(sie_dir),
        .sie_end(sie_end), .sie_ok(sie_ok),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_eod(tx_eod),
        .done(done), .done_cnt(done_cnt), .done_ovr(done_ovr),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Packet memory model: synchronous write, one-cycle read
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as the design writes memory or emits bytes
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_wr.size() == 0)
                    chk(1'b0, "R3", "unexpected mem write", int'({mem_addr, mem_wdata}), 0);
                else begin
                    logic [PB_AW+15:0] e;
                    e = exp_wr.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R2", "mem write {addr,data}",
                        int'({mem_addr, mem_wdata}), int'(e));
                end
            end
            if (tx_valid) begin
                if (exp_tx.size() == 0)
                    chk(1'b0, "R7", "unexpected tx byte", int'(tx_byte), 0);
                else begin
                    logic [7:0] b;
                    b = exp_tx.pop_front();
                    chk(tx_byte == b, "R6", "tx byte", int'(tx_byte), int'(b));
                end
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic config_slot(input int ep, input bit slot, input int base,
                               input int cap, input int cnt, input bit dbl);
        cfg_we = 1'b1; cfg_ep = PB_EPW'(ep); cfg_slot = slot;
        cfg_base = PB_AW'(base); cfg_cap = PB_CW'(cap); cfg_cnt = PB_CW'(cnt); cfg_dbl = dbl;
        step();
        cfg_we = 1'b0;
    endtask

    // Driver: receive packet of n bytes seed, seed+1, ... into a slot
    task automatic rx_pkt(input int ep, input bit slot, input int base, input int cap,
                          input int n, input int seed, input bit ok, input string req);
        int acc;
        acc = (n < cap) ? n : cap;
        for (int i = 1; i < acc; i += 2)
            exp_wr.push_back({PB_AW'(base + i/2), 8'(seed + i), 8'(seed + i - 1)});
        if (acc % 2 == 1)
            exp_wr.push_back({PB_AW'(base + acc/2), 8'h00, 8'(seed + acc - 1)});
        sie_start = 1'b1; sie_ep = PB_EPW'(ep); sie_dir = 1'b0;
        step();
        sie_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1; rx_byte = 8'(seed + i);
            step();
        end
        rx_valid = 1'b0;
        sie_end = 1'b1; sie_ok = ok;
        step();
        sie_end = 1'b0; sie_ok = 1'b0;
        chk(done == 1'b1, "R5", {req, " done pulse"}, int'(done), 1);
        chk(done_cnt == PB_CW'(acc), "R5", {req, " done_cnt"}, int'(done_cnt), acc);
        chk(done_ovr == (n > cap), (n > cap) ? "R3" : "R5", {req, " done_ovr"},
            int'(done_ovr), int'(n > cap));
        rd_ep = PB_EPW'(ep); rd_slot = slot;
        #1;
        chk(rd_cnt == PB_CW'(acc), "R5", {req, " count write-back"}, int'(rd_cnt), acc);
        step();
        chk(done == 1'b0, "R5", {req, " done one cycle"}, int'(done), 0);
        chk(exp_wr.size() == 0, "R2", {req, " writes outstanding"}, exp_wr.size(), 0);
        exp_wr.delete();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        #1;
        // R9: reset state
        chk(done == 1'b0, "R9", "done after reset", int'(done), 0);
        chk(tx_valid == 1'b0, "R9", "tx_valid after reset", int'(tx_valid), 0);
        chk(mem_we == 1'b0, "R9", "mem_we after reset", int'(mem_we), 0);
        chk(rd_tog == 1'b0, "R9", "toggle after reset", int'(rd_tog), 0);

        // Single-buffered endpoint 1: slot0 transmit at 0x010, slot1 receive at 0x020 cap 8
        config_slot(1, 1'b0, 'h010, 16, 5, 1'b0);
        config_slot(1, 1'b1, 'h020, 8, 0, 1'b0);

        rx_pkt(1, 1'b1, 'h020, 8, 6, 'h10, 1'b1, "R1 R2 even rx");
        rx_pkt(1, 1'b1, 'h020, 8, 11, 'h30, 1'b1, "R3 overrun rx");
        rx_pkt(1, 1'b1, 'h020, 8, 5, 'h50, 1'b1, "R4 odd rx");

        // Transmit from slot 0: 5 bytes A1 B2 C3 D4 E5
        mem['h010] = 16'hB2A1; mem['h011] = 16'hD4C3; mem['h012] = 16'h00E5;
        exp_tx.push_back(8'hA1); exp_tx.push_back(8'hB2); exp_tx.push_back(8'hC3);
        exp_tx.push_back(8'hD4); exp_tx.push_back(8'hE5);
        sie_start = 1'b1; sie_ep = 3'd1; sie_dir = 1'b1;
        step();
        sie_start = 1'b0;
        chk(tx_eod == 1'b0, "R7", "eod with bytes left", int'(tx_eod), 0);
        tx_req = 1'b1;
        repeat (3) step();
        tx_req = 1'b0;
        step();
        tx_req = 1'b1;
        repeat (2) step();
        tx_req = 1'b0;
        step();
        chk(tx_eod == 1'b1, "R7", "eod after length", int'(tx_eod), 1);
        chk(exp_tx.size() == 0, "R6", "tx bytes outstanding", exp_tx.size(), 0);
        tx_req = 1'b1;
        step();
        tx_req = 1'b0;
        step();
        chk(tx_valid == 1'b0, "R7", "no byte past end", int'(tx_valid), 0);
        sie_end = 1'b1; sie_ok = 1'b1;
        step();
        sie_end = 1'b0; sie_ok = 1'b0;
        chk(done == 1'b1 && done_cnt == 10'd5, "R5", "tx done count",
            int'(done_cnt), 5);
        step();

        // Double-buffered endpoint 3: slot0 at 0x040, slot1 at 0x050
        config_slot(3, 1'b0, 'h040, 4, 0, 1'b1);
        config_slot(3, 1'b1, 'h050, 4, 0, 1'b1);
        rd_ep = 3'd3; #1;
        chk(rd_tog == 1'b0, "R8", "toggle after config", int'(rd_tog), 0);
        rx_pkt(3, 1'b0, 'h040, 4, 2, 'h60, 1'b1, "R1 dbl first");
        chk(rd_tog == 1'b1, "R8", "toggle after ok", int'(rd_tog), 1);
        rx_pkt(3, 1'b1, 'h050, 4, 2, 'h70, 1'b0, "R8 dbl failed");
        chk(rd_tog == 1'b1, "R8", "toggle held after fail", int'(rd_tog), 1);
        rx_pkt(3, 1'b1, 'h050, 4, 3, 'h80, 1'b1, "R8 dbl retry");
        chk(rd_tog == 1'b0, "R8", "toggle after second ok", int'(rd_tog), 0);
        rx_pkt(3, 1'b0, 'h040, 4, 4, 'h90, 1'b1, "R1 dbl swap back");
        chk(rd_tog == 1'b1, "R8", "toggle before reconfig", int'(rd_tog), 1);
        config_slot(3, 1'b0, 'h040, 4, 0, 1'b1);
        rd_ep = 3'd3; #1;
        chk(rd_tog == 1'b0, "R8", "toggle cleared by config", int'(rd_tog), 0);

        step();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule